// File: doc/BRIEF.md
# Wavefront-Pipelined Ripple-Carry Adder

This block adds two unsigned operands and a carry-in. It is pipelined so finely that every bit position is its own stage. Each stage holds one full adder. It fires only when two requests meet: the operand pair for its bit, and the carry arriving from the stage below. It then passes its carry upward on two complementary rails.

Because bit i of an addition is resolved i cycles after bit 0, a triangular input delay lines each operand bit up with the carry that will reach it. A matching triangular output delay gathers the sum bits into one parallel word. Up to one new addition can enter per cycle. Consecutive additions travel up the carry chain as a diagonal wavefront, so every stage can hold a different addition at the same time.

A consumer that is not ready freezes the whole structure in place. A producer presents operands and carry-in on two separate valid/ready streams that are consumed together.

Top module: `wave_rca`

## Requirements
- R1: When a result is delivered (`res_valid` and `res_ready` high at a clock edge), `{res_cout, res_sum}` equals `op_a + op_b + cin` of the matching addition, computed as a WIDTH+1 bit unsigned sum.
- R2: With no stall, an addition accepted at a clock edge shows `res_valid` high after exactly WIDTH-1 further edges, and not earlier.
- R3: An addition is accepted only when `op_valid` and `cin_valid` are both high. `op_ready` and `cin_ready` are such that both streams are acknowledged in the same cycle or neither is. A lone valid on one stream is never consumed and produces no result.
- R4: While `res_ready` stays high, a new addition is accepted every cycle, and back-to-back additions are delivered on consecutive cycles.
- R5: While `res_valid` is high and `res_ready` low, `res_sum`, `res_cout` and `res_valid` hold, and both ready outputs are low. Every accepted addition is delivered exactly once, in acceptance order.
- R6: After the asynchronous active-low reset, `res_valid` is low, and it stays low until the first accepted addition has passed through the top bit stage.
- R7: Inside the chain, a carry that is present has exactly one of its two rails high, and an absent carry has both rails low. A carry that propagates through all WIDTH stages (for example all-ones plus zero with carry-in 1) appears correctly at `res_cout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_valid | input | 1 | Operand pair present |
| op_ready | output | 1 | Operand pair consumed this cycle if valid |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| cin_valid | input | 1 | Carry-in present |
| cin_ready | output | 1 | Carry-in consumed this cycle if valid |
| cin | input | 1 | Carry-in of bit 0 |
| res_valid | output | 1 | Parallel result present |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_sum | output | WIDTH | Collected sum bits |
| res_cout | output | 1 | Carry out of the top bit |

## Verification
The hard case is a result retiring in the same cycle that a new addition enters at the bottom of the chain. This is most likely just as backpressure lifts, when the whole wavefront starts moving again. The bench provokes it by feeding operands and carry-ins with random gaps while toggling `res_ready` at random. It judges the outcome with a queue of expected sums kept in acceptance order: a lost, duplicated or reordered addition shows up as a mismatch or as a non-empty queue after the final drain. Frozen values across every stalled cycle are compared as well.

// File: rtl/wave_rca_pkg.sv
package wave_rca_pkg;

  // Carry on two complementary rails; both low means no carry is present.
  typedef struct packed {
    logic hi;
    logic lo;
  } rail_t;

  localparam rail_t RAIL_EMPTY = '{hi: 1'b0, lo: 1'b0};

  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // Each rail is evaluated from its own polarity of the incoming carry.
  function automatic rail_t fa_carry(input logic a, input logic b, input rail_t c);
    rail_t r;
    r.hi = (a & b) | ((a | b) & c.hi);
    r.lo = (~a & ~b) | ((~a | ~b) & c.lo);
    return r;
  endfunction

endpackage

// File: rtl/wave_rca_delay.sv
module wave_rca_delay #(
  parameter int DW    = 1,
  parameter int DEPTH = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [DW-1:0] tap_q [DEPTH];
      logic [DW-1:0] tap_n [DEPTH];

      always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
          tap_n[k] = tap_q[k];
          if (en) tap_n[k] = (k == 0) ? d : tap_q[k-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < DEPTH; k++) tap_q[k] <= '0;
        end else begin
          for (int k = 0; k < DEPTH; k++) tap_q[k] <= tap_n[k];
        end
      end

      assign q = tap_q[DEPTH-1];

      assert_delay_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));
    end
  endgenerate

endmodule

// File: rtl/wave_rca_cell.sv
module wave_rca_cell
  import wave_rca_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  ab_req,
  input  logic  a,
  input  logic  b,
  input  logic  c_req,
  input  rail_t c_in,
  output logic  done,
  output logic  sum,
  output rail_t c_out
);

  logic  fire;
  logic  done_n, sum_n;
  rail_t rail_n;

  // Join: the stage evaluates only when both bundled streams are present.
  assign fire = ab_req & c_req;

  always_comb begin
    done_n = done;
    sum_n  = sum;
    rail_n = c_out;
    if (en) begin
      done_n = fire;
      sum_n  = fire ? fa_sum(a, b, c_in.hi) : 1'b0;
      rail_n = fire ? fa_carry(a, b, c_in) : RAIL_EMPTY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      sum   <= 1'b0;
      c_out <= RAIL_EMPTY;
    end else begin
      done  <= done_n;
      sum   <= sum_n;
      c_out <= rail_n;
    end
  end

  assert_rail_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot({c_out.hi, c_out.lo}));

  assert_rail_spacer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (c_out == RAIL_EMPTY));

  assert_carry_rail_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    c_req |-> $onehot({c_in.hi, c_in.lo}));

  assert_join_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ab_req == c_req);

  assert_cell_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(done) && $stable(sum) && $stable(c_out));

endmodule

// File: rtl/wave_rca.sv
module wave_rca
  import wave_rca_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             cin_valid,
  output logic             cin_ready,
  input  logic             cin,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [WIDTH-1:0] res_sum,
  output logic             res_cout
);

  localparam int TOP = WIDTH - 1;

  logic             advance;
  logic             accept;
  logic [WIDTH-1:0] lane_req;
  logic [WIDTH-1:0] lane_a, lane_b;
  logic [WIDTH-1:0] done;
  logic [WIDTH-1:0] sum_bit;
  rail_t            rails [WIDTH];
  rail_t            cin_rail;

  // The whole wavefront moves together unless a finished result is refused.
  assign advance   = ~res_valid | res_ready;
  assign op_ready  = advance & cin_valid;
  assign cin_ready = advance & op_valid;
  assign accept    = advance & op_valid & cin_valid;

  assign cin_rail.hi = accept & cin;
  assign cin_rail.lo = accept & ~cin;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      logic [2:0] skew_q;

      // Bit i of the operands waits i cycles for the rippling carry.
      wave_rca_delay #(.DW(3), .DEPTH(i)) u_skew (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (advance),
        .d     ({accept, op_a[i], op_b[i]}),
        .q     (skew_q)
      );
      assign lane_req[i] = skew_q[2];
      assign lane_a[i]   = skew_q[1];
      assign lane_b[i]   = skew_q[0];

      if (i == 0) begin : g_first
        wave_rca_cell u_cell (
          .clk    (clk),
          .rst_n  (rst_n),
          .en     (advance),
          .ab_req (lane_req[i]),
          .a      (lane_a[i]),
          .b      (lane_b[i]),
          .c_req  (accept),
          .c_in   (cin_rail),
          .done   (done[i]),
          .sum    (sum_bit[i]),
          .c_out  (rails[i])
        );
      end else begin : g_rest
        wave_rca_cell u_cell (
          .clk    (clk),
          .rst_n  (rst_n),
          .en     (advance),
          .ab_req (lane_req[i]),
          .a      (lane_a[i]),
          .b      (lane_b[i]),
          .c_req  (done[i-1]),
          .c_in   (rails[i-1]),
          .done   (done[i]),
          .sum    (sum_bit[i]),
          .c_out  (rails[i])
        );
      end

      // Sum bit i waits until the top bit of the same addition is ready.
      wave_rca_delay #(.DW(1), .DEPTH(TOP - i)) u_deskew (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (advance),
        .d     (sum_bit[i]),
        .q     (res_sum[i])
      );
    end
  endgenerate

  assign res_valid = done[TOP];
  assign res_cout  = rails[TOP].hi;

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_sum) && $stable(res_cout));

  assert_no_intake_in_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !op_ready && !cin_ready);

  assert_joint_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) == (cin_valid && cin_ready));

  assert_chain_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    advance && op_valid && cin_valid |=> done[0]);

endmodule

// File: tb/wave_rca_bench.sv
module wave_rca_bench;
  localparam int  W      = 32;
  localparam time PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         op_valid, op_ready, cin_valid, cin_ready, cin;
  logic [W-1:0] op_a, op_b;
  logic         res_valid, res_ready, res_cout;
  logic [W-1:0] res_sum;

  int n_checks = 0;
  int n_fail   = 0;

  logic [W:0] exp_q [$];
  logic       stall_prev = 1'b0;
  logic [W:0] held;
  int         retired = 0;

  logic         d_opv = 0, d_cinv = 0, d_cin = 0, d_rdy = 1;
  logic [W-1:0] d_a = '0, d_b = '0;

  always #(PERIOD/2) clk = ~clk;

  wave_rca #(.WIDTH(W)) u_wave_rca (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_ready(op_ready), .op_a(op_a), .op_b(op_b),
    .cin_valid(cin_valid), .cin_ready(cin_ready), .cin(cin),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_sum(res_sum), .res_cout(res_cout)
  );

  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    op_valid = d_opv; cin_valid = d_cinv; cin = d_cin;
    op_a = d_a; op_b = d_b; res_ready = d_rdy;
    #1;
    if (stall_prev)
      chk(res_valid && ({res_cout, res_sum} == held), "R5 hold", {res_cout, res_sum}, held);
    if ((op_valid && op_ready) || (cin_valid && cin_ready)) begin
      chk(op_valid && op_ready && cin_valid && cin_ready, "R3 joint ack",
          {op_ready, cin_ready}, 2'b11);
      exp_q.push_back(model(op_a, op_b, cin));
    end
    if (res_valid && res_ready) begin
      retired++;
      if (exp_q.size() == 0) chk(1'b0, "R5 extra result", {res_cout, res_sum}, 0);
      else begin
        logic [W:0] e;
        e = exp_q.pop_front();
        chk({res_cout, res_sum} == e, "R1 sum", {res_cout, res_sum}, e);
      end
    end
    stall_prev = res_valid && !res_ready;
    held = {res_cout, res_sum};
  endtask

  task automatic add1(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    d_opv = 1; d_cinv = 1; d_a = a; d_b = b; d_cin = c;
    tick();
    d_opv = 0; d_cinv = 0;
  endtask

  task automatic drain();
    d_opv = 0; d_cinv = 0; d_rdy = 1;
    for (int k = 0; k < W + 4; k++) tick();
  endtask

  initial begin
    #(PERIOD * 150000);
    n_fail++; n_checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int seed;
    int lat;
    logic bad;
    int first;
    seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0;
    op_valid = 0; cin_valid = 0; cin = 0; op_a = '0; op_b = '0; res_ready = 1;
    for (int k = 0; k < 3; k++) tick();
    chk(!res_valid, "R6 reset valid", res_valid, 0);
    chk(!op_ready && !cin_ready, "R6 reset ready idle", {op_ready, cin_ready}, 0);
    @(negedge clk); rst_n = 1'b1;
    tick();
    chk(!res_valid, "R6 after release", res_valid, 0);

    // R3: one stream alone is never consumed
    bad = 0; d_opv = 1; d_a = 5; d_b = 7;
    for (int k = 0; k < 40; k++) begin tick(); if (op_ready || res_valid) bad = 1; end
    chk(!bad, "R3 operands alone", bad, 0);
    bad = 0; d_opv = 0; d_cinv = 1;
    for (int k = 0; k < 40; k++) begin tick(); if (cin_ready || res_valid) bad = 1; end
    chk(!bad, "R3 carry alone", bad, 0);
    d_cinv = 0;
    chk(exp_q.size() == 0, "R3 nothing queued", exp_q.size(), 0);

    // R2 / R6: latency of a lone addition
    add1(32'h1234_5678, 32'h0F0F_0F0F, 1'b1);
    lat = 0;
    for (int k = 1; k <= W + 2; k++) begin
      tick();
      if (res_valid && lat == 0) lat = k;
    end
    chk(lat == W, "R2 latency", lat, W);

    // R7: full carry propagation corners
    add1('1, '0, 1'b1);
    add1('1, '1, 1'b1);
    add1('0, '0, 1'b0);
    add1(32'h8000_0000, 32'h8000_0000, 1'b0);
    add1(32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    drain();
    chk(exp_q.size() == 0, "R7 corners delivered", exp_q.size(), 0);

    // R4: back-to-back burst with consumer always ready
    d_rdy = 1;
    for (int k = 0; k < 12; k++) begin
      d_opv = 1; d_cinv = 1; d_a = W'($urandom); d_b = W'($urandom); d_cin = k[0];
      tick();
      chk(op_ready && cin_ready, "R4 accept each cycle", {op_ready, cin_ready}, 2'b11);
    end
    d_opv = 0; d_cinv = 0;
    first = -1; bad = 0;
    for (int k = 0; k < W + 4; k++) begin
      tick();
      if (res_valid && first < 0) first = k;
      if (first >= 0 && k < first + 12 && !res_valid) bad = 1;
    end
    chk(!bad && first >= 0, "R4 consecutive results", bad, 0);

    // Random traffic with random backpressure (R1, R5)
    for (int k = 0; k < 4000; k++) begin
      d_opv  = ($urandom % 10) < 8;
      d_cinv = ($urandom % 10) < 8;
      d_cin  = $urandom % 2;
      d_a    = ($urandom % 8 == 0) ? '1 : W'($urandom);
      d_b    = W'($urandom);
      d_rdy  = ($urandom % 10) < 7;
      tick();
    end
    drain();
    chk(exp_q.size() == 0, "R5 no loss", exp_q.size(), 0);
    chk(!res_valid, "R5 idle after drain", res_valid, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule